// File: doc/BRIEF.md
# Host-Controlled Boot Hold Gate

After reset, this block decides whether a processor core may start fetching instructions. When the boot-mode pins select host boot, it holds the core stalled and raises a semaphore flag in a small host-visible register file. While the core is held, an external host loads the core's memories through its own write paths, which lie outside this block. When the loading is done, the host clears the flag.

The gate then emits a one-cycle strobe that moves the interrupt vector table to page 0 of internal memory. On the next cycle it releases the core with a start address of zero. For any other boot mode the gate stays idle and never stalls the core.

The host reaches the register file through a request/response stream. A request carries a write flag, a register index and write data, and it transfers on a cycle where both `hreq_valid` and `hreq_ready` are high. Writes produce no response. A read produces one response beat in the cycle after the request transfers. That beat stays on `hrsp_data` until the host takes it by raising `hrsp_ready`. While a response is waiting, `hreq_ready` stays low, so no new request can be accepted.

Top module: `boot_hold_gate`

## Requirements
- R1: `boot_sel` is sampled on every clock edge while `rst_n` is low, and the value from the last such edge selects the mode. Host boot is code 3'b010. In host mode, `core_hold` is high during reset once that first edge has occurred.
- R2: In host mode, the first cycle after reset release sets the semaphore to 1. The semaphore is bit 0 of register index 0. During that first cycle `hreq_ready` is low, so no host access can come before the set.
- R3: `core_hold` stays high for as long as the semaphore is 1. A host write of a nonzero value to index 0 leaves the semaphore at 1, and the core stays held.
- R4: A host write of the value 0 to index 0 while the core is held clears the semaphore. `vec_remap` is then high for exactly the one cycle after the write transfers, and `core_hold` is still high during that cycle.
- R5: In the cycle after the `vec_remap` pulse, `core_hold` is low, `core_run` is high and `core_start_addr` is 0. `core_run` then stays high until the next reset.
- R6: Once the core has been released, writes to index 0 have no effect. The semaphore reads 0, `core_run` stays high, and no further `vec_remap` pulse occurs until reset.
- R7: In any mode other than host boot, `core_hold`, `vec_remap` and `core_run` stay low. Index 0 reads 0 and ignores writes.
- R8: A request transfers when `hreq_valid` and `hreq_ready` are both high. A read response appears on `hrsp_valid`/`hrsp_data` in the cycle after its request transfers. The response stays stable until `hrsp_ready` is high, and `hreq_ready` is low while it waits.
- R9: Register index 1 is read-only status: bit 0 is `core_hold`, bit 1 is `core_run`, and bit 2 is set in host mode. All other indexes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; boot mode is sampled while low |
| boot_sel | input | 3 | Boot mode pins (3'b010 = host boot) |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Gate can accept a request |
| hreq_write | input | 1 | 1 = write, 0 = read |
| hreq_addr | input | 4 | Register index |
| hreq_wdata | input | 16 | Write data |
| hrsp_valid | output | 1 | Read response valid |
| hrsp_ready | input | 1 | Host takes the read response |
| hrsp_data | output | 16 | Read response data |
| core_hold | output | 1 | Stall the core; no instruction fetch |
| vec_remap | output | 1 | One-cycle vector table remap strobe |
| core_run | output | 1 | Core released |
| core_start_addr | output | 24 | Start address for the released core |

## Verification
The properties assume that reset is held for at least one clock edge, so that the sampled boot mode is defined when reset ends. They also assume that `hrsp_ready` is a plain level from the host and does not depend combinationally on `hrsp_valid`. The stimulus holds reset for four edges in every scenario. It changes all host-side inputs only at falling clock edges, and it lowers `hrsp_ready` only in the scenario that exercises a stalled response.

// File: rtl/boot_gate_pkg.sv
package boot_gate_pkg;
  typedef enum logic [2:0] {
    GS_INIT  = 3'd0,
    GS_IDLE  = 3'd1,
    GS_WAIT  = 3'd2,
    GS_REMAP = 3'd3,
    GS_RUN   = 3'd4
  } gate_state_t;

  localparam int REG_SEM_IDX  = 0;
  localparam int REG_STAT_IDX = 1;
  localparam int STAT_HOLD_BIT = 0;
  localparam int STAT_RUN_BIT  = 1;
  localparam int STAT_HOST_BIT = 2;
endpackage

// File: rtl/bgate_mode_cap.sv
module bgate_mode_cap #(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] HOST_MODE = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] boot_sel,
  output logic              host_mode
);
  logic [MODE_W-1:0] mode_q;

  // pins are captured only while reset is low, then frozen
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= boot_sel;
  end

  assign host_mode = (mode_q == HOST_MODE);
endmodule

// File: rtl/bgate_seq.sv
module bgate_seq
  import boot_gate_pkg::*;
#(
  parameter int PC_W = 24,
  parameter logic [PC_W-1:0] START_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_mode,
  input  logic            sem_wr_en,
  input  logic            sem_wr_val,
  output logic            sem_q,
  output logic            in_init,
  output logic            core_hold,
  output logic            vec_remap,
  output logic            core_run,
  output logic [PC_W-1:0] core_start_addr
);
  gate_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_INIT;
      sem_q   <= 1'b0;
    end else begin
      unique case (state_q)
        GS_INIT: begin
          if (host_mode) begin
            sem_q   <= 1'b1;
            state_q <= GS_WAIT;
          end else begin
            state_q <= GS_IDLE;
          end
        end
        GS_WAIT: begin
          if (sem_wr_en) begin
            sem_q <= sem_wr_val;
            if (!sem_wr_val) state_q <= GS_REMAP;
          end
        end
        GS_REMAP: state_q <= GS_RUN;
        GS_RUN:   state_q <= GS_RUN;
        GS_IDLE:  state_q <= GS_IDLE;
        default:  state_q <= GS_INIT;
      endcase
    end
  end

  assign in_init   = (state_q == GS_INIT);
  assign core_hold = (in_init && host_mode) || (state_q == GS_WAIT) || (state_q == GS_REMAP);
  assign vec_remap = (state_q == GS_REMAP);
  assign core_run  = (state_q == GS_RUN);
  assign core_start_addr = core_run ? START_ADDR : '0;
endmodule

// File: rtl/bgate_host_port.sv
module bgate_host_port
  import boot_gate_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_init,
  input  logic              hreq_valid,
  output logic              hreq_ready,
  input  logic              hreq_write,
  input  logic [ADDR_W-1:0] hreq_addr,
  input  logic [DATA_W-1:0] hreq_wdata,
  output logic              hrsp_valid,
  input  logic              hrsp_ready,
  output logic [DATA_W-1:0] hrsp_data,
  input  logic              sem_q,
  input  logic              st_hold,
  input  logic              st_run,
  input  logic              st_host,
  output logic              sem_wr_en,
  output logic              sem_wr_val
);
  localparam logic [ADDR_W-1:0] A_SEM  = ADDR_W'(REG_SEM_IDX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT_IDX);

  logic              fire;
  logic [DATA_W-1:0] rd_mux;

  assign hreq_ready = !in_init && (!hrsp_valid || hrsp_ready);
  assign fire       = hreq_valid && hreq_ready;
  assign sem_wr_en  = fire && hreq_write && (hreq_addr == A_SEM);
  assign sem_wr_val = |hreq_wdata;

  always_comb begin
    rd_mux = '0;
    if (hreq_addr == A_SEM) begin
      rd_mux[0] = sem_q;
    end else if (hreq_addr == A_STAT) begin
      rd_mux[STAT_HOLD_BIT] = st_hold;
      rd_mux[STAT_RUN_BIT]  = st_run;
      rd_mux[STAT_HOST_BIT] = st_host;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrsp_valid <= 1'b0;
      hrsp_data  <= '0;
    end else if (fire && !hreq_write) begin
      hrsp_valid <= 1'b1;
      hrsp_data  <= rd_mux;
    end else if (hrsp_ready) begin
      hrsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_hold_gate.sv
module boot_hold_gate #(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] HOST_MODE = 3'b010,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int PC_W   = 24,
  parameter logic [PC_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] boot_sel,
  input  logic              hreq_valid,
  output logic              hreq_ready,
  input  logic              hreq_write,
  input  logic [ADDR_W-1:0] hreq_addr,
  input  logic [DATA_W-1:0] hreq_wdata,
  output logic              hrsp_valid,
  input  logic              hrsp_ready,
  output logic [DATA_W-1:0] hrsp_data,
  output logic              core_hold,
  output logic              vec_remap,
  output logic              core_run,
  output logic [PC_W-1:0]   core_start_addr
);
  logic host_mode;
  logic sem_q;
  logic in_init;
  logic sem_wr_en;
  logic sem_wr_val;

  bgate_mode_cap #(.MODE_W(MODE_W), .HOST_MODE(HOST_MODE)) u_mode (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .host_mode(host_mode)
  );

  bgate_seq #(.PC_W(PC_W), .START_ADDR(START_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .sem_wr_en(sem_wr_en), .sem_wr_val(sem_wr_val),
    .sem_q(sem_q), .in_init(in_init),
    .core_hold(core_hold), .vec_remap(vec_remap), .core_run(core_run),
    .core_start_addr(core_start_addr)
  );

  bgate_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .in_init(in_init),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_write(hreq_write),
    .hreq_addr(hreq_addr), .hreq_wdata(hreq_wdata),
    .hrsp_valid(hrsp_valid), .hrsp_ready(hrsp_ready), .hrsp_data(hrsp_data),
    .sem_q(sem_q), .st_hold(core_hold), .st_run(core_run), .st_host(host_mode),
    .sem_wr_en(sem_wr_en), .sem_wr_val(sem_wr_val)
  );
endmodule

// File: rtl/bgate_chk.sv
module bgate_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_mode,
  input logic              hreq_ready,
  input logic              hrsp_valid,
  input logic              hrsp_ready,
  input logic [DATA_W-1:0] hrsp_data,
  input logic              core_hold,
  input logic              vec_remap,
  input logic              core_run
);
  // R4
  remap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_remap |=> !vec_remap);
  // R4
  remap_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_remap |-> core_hold);
  // R5
  release_after_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_remap |=> (core_run && !core_hold));
  // R5
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> core_run);
  // R3
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> $past(vec_remap));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |-> (!core_hold && !vec_remap && !core_run));
  // R8
  rsp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hrsp_valid && !hrsp_ready) |=> (hrsp_valid && $stable(hrsp_data)));
  // R8
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hrsp_valid && !hrsp_ready) |-> !hreq_ready);
endmodule

bind boot_hold_gate bgate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
  .hreq_ready(hreq_ready), .hrsp_valid(hrsp_valid), .hrsp_ready(hrsp_ready),
  .hrsp_data(hrsp_data), .core_hold(core_hold), .vec_remap(vec_remap),
  .core_run(core_run)
);

// File: tb/boot_hold_gate_test.sv
`timescale 1ns/1ps
module boot_hold_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  boot_sel = 3'b010;
  logic        hreq_valid = 1'b0;
  logic        hreq_ready;
  logic        hreq_write = 1'b0;
  logic [3:0]  hreq_addr = '0;
  logic [15:0] hreq_wdata = '0;
  logic        hrsp_valid;
  logic        hrsp_ready = 1'b1;
  logic [15:0] hrsp_data;
  logic        core_hold;
  logic        vec_remap;
  logic        core_run;
  logic [23:0] core_start_addr;

  int tests_run = 0;
  int tests_failed = 0;
  int remap_cnt = 0;
  int hold_cnt = 0;
  int hold_gap = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  boot_hold_gate uut (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_write(hreq_write),
    .hreq_addr(hreq_addr), .hreq_wdata(hreq_wdata),
    .hrsp_valid(hrsp_valid), .hrsp_ready(hrsp_ready), .hrsp_data(hrsp_data),
    .core_hold(core_hold), .vec_remap(vec_remap), .core_run(core_run),
    .core_start_addr(core_start_addr)
  );

  always @(negedge clk) begin
    if (rst_n && vec_remap) remap_cnt++;
    if (rst_n && core_hold) hold_cnt++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [2:0] mode);
    @(negedge clk);
    rst_n = 1'b0;
    boot_sel = mode;
    hreq_valid = 1'b0;
    hrsp_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    remap_cnt = 0;
    hold_cnt = 0;
    rst_n = 1'b1;
    boot_sel = ~mode;
  endtask

  task automatic host_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    hreq_valid = 1'b1; hreq_write = 1'b1; hreq_addr = a; hreq_wdata = d;
    while (!hreq_ready) @(negedge clk);
    @(posedge clk);
    #1 hreq_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_read(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    hreq_valid = 1'b1; hreq_write = 1'b0; hreq_addr = a;
    while (!hreq_ready) @(negedge clk);
    @(posedge clk);
    #1 hreq_valid = 1'b0;
    @(negedge clk);
    d = hrsp_valid ? hrsp_data : 16'hdead;
  endtask

  task automatic test_reset_and_arm();
    logic [15:0] d;
    @(negedge clk);
    rst_n = 1'b0; boot_sel = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 hold in reset", core_hold, 1);
    chk("R1 no run in reset", core_run, 0);
    chk("R8 no rsp in reset", hrsp_valid, 0);
    rst_n = 1'b1; boot_sel = 3'b000;
    #1;
    chk("R2 ready low first cycle", hreq_ready, 0);
    chk("R2 hold first cycle", core_hold, 1);
    host_read(4'd0, d);
    chk("R2 semaphore set", d, 16'h0001);
  endtask

  task automatic test_host_boot();
    logic [15:0] d;
    do_reset(3'b010);
    host_write(4'd0, 16'h0100);
    host_read(4'd0, d);
    chk("R3 nonzero write keeps sem", d, 16'h0001);
    hold_gap = hold_cnt;
    repeat (40) @(negedge clk);
    chk("R3 hold continuous", hold_cnt - hold_gap, 40);
    chk("R3 no remap while set", remap_cnt, 0);
    host_read(4'd1, d);
    chk("R9 status held", d, 16'h0005);
    host_write(4'd0, 16'h0000);
    chk("R4 remap pulse", vec_remap, 1);
    chk("R4 hold during remap", core_hold, 1);
    chk("R4 not run during remap", core_run, 0);
    @(negedge clk);
    chk("R4 remap one cycle", vec_remap, 0);
    chk("R5 run", core_run, 1);
    chk("R5 hold released", core_hold, 0);
    chk("R5 start addr", core_start_addr, 0);
    host_write(4'd0, 16'h0001);
    host_read(4'd0, d);
    chk("R6 sem write ignored", d, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R6 still running", core_run, 1);
    chk("R6 single remap", remap_cnt, 1);
    host_read(4'd1, d);
    chk("R9 status run", d, 16'h0006);
    host_read(4'd7, d);
    chk("R9 unused index", d, 16'h0000);
  endtask

  task automatic test_backpressure();
    logic [15:0] d;
    @(negedge clk);
    hrsp_ready = 1'b0;
    host_read(4'd1, d);
    chk("R8 response after one cycle", d, 16'h0006);
    chk("R8 ready low while pending", hreq_ready, 0);
    repeat (3) @(negedge clk);
    chk("R8 valid held", hrsp_valid, 1);
    chk("R8 data held", hrsp_data, 16'h0006);
    hrsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 response taken", hrsp_valid, 0);
    chk("R8 ready back", hreq_ready, 1);
  endtask

  task automatic test_other_mode(logic [2:0] mode);
    logic [15:0] d;
    do_reset(mode);
    repeat (3) @(negedge clk);
    host_write(4'd0, 16'h0000);
    host_write(4'd0, 16'h0001);
    host_read(4'd0, d);
    chk("R7 sem reads zero", d, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R7 never held", hold_cnt, 0);
    chk("R7 no remap", remap_cnt, 0);
    chk("R7 no run", core_run, 0);
    host_read(4'd1, d);
    chk("R9 status idle", d, 16'h0000);
  endtask

  initial begin
    test_reset_and_arm();
    test_host_boot();
    test_backpressure();
    test_other_mode(3'b000);
    test_other_mode(3'b111);
    test_other_mode(3'b011);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule